// File: doc/BRIEF.md
# Shared Frame Buffer Arbiter

This block lets one single-ported asynchronous SRAM serve two masters: a processor bus port that reads and writes 16-bit pixel words, and a raster engine that streams the visible picture to a 12-bit colour output. Each clock is one access slot. The raster engine walks the visible area in scan order. It starts at word zero of the buffer, and each next word is the pixel to its right, with lines stacked one after another. Each word carries one pixel, with red, green and blue nibbles in bits 11:8, 7:4 and 3:0. Bits 15:12 are not shown.

The processor always wins a slot. When it takes a slot in which the raster engine wanted a pixel, the scan is not delayed. The pixel shown for that slot is whatever was on the shared data bus: the processor's write data, or the word the processor read. A 32-bit processor store is issued as two word requests to neighbouring addresses. The processor port answers every accepted request exactly one clock later. Requests whose address falls outside the decoded buffer window get no answer and never reach the SRAM. Outside the visible area the raster engine leaves the SRAM idle and drives black.

Top module: `fb_arbiter`

## Requirements
- R1: While reset is held, `vid_de`, `vid_rgb` and `cpu_ack` are 0 and all three SRAM strobes (`sram_ce_n`, `sram_oe_n`, `sram_we_n`) are high.
- R2: The pixel at column x, line y is fetched from SRAM word y*H_ACT+x. It appears on `vid_rgb` with `vid_de`=1 on the clock after its fetch slot, in raster order. The first pixel after reset is (0,0).
- R3: `vid_rgb` carries bits 11:0 of the fetched word (red 11:8, green 7:4, blue 3:0); bits 15:12 of the word have no effect on the output.
- R4: In a slot outside the visible area the raster engine makes no SRAM access (`sram_ce_n` stays high unless the processor is accessing), and on the following clock `vid_de` and `vid_rgb` are 0.
- R5: A processor write to address BASE+n (n below H_ACT*V_ACT) drives word n with `sram_we_n` low for that one slot, stores `cpu_wdata`, and raises `cpu_ack` on the next clock.
- R6: A processor read to address BASE+n raises `cpu_ack` on the next clock with `cpu_rdata` equal to the full 16-bit word n.
- R7: A request with an address below BASE, or at or above BASE+H_ACT*V_ACT, gets no `cpu_ack` and does not write the SRAM.
- R8: A processor access in a visible-area slot takes the SRAM. That slot's pixel shows bits 11:0 of the bus data (the write data, or the word read), and the following pixels keep their normal timing and contents.
- R9: Two word writes to consecutive addresses change exactly two horizontally adjacent pixels and leave their neighbours untouched.
- R10: After the last slot of the frame, the scan restarts at word 0 with pixel (0,0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, one SRAM access per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, one cycle per access |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | CPU_AW | Processor word address |
| cpu_wdata | input | 16 | Write data |
| cpu_ack | output | 1 | Access done, one cycle after the request |
| cpu_rdata | output | 16 | Read data, valid with cpu_ack |
| sram_addr | output | AW | SRAM word address |
| sram_dq_o | output | 16 | Data driven to the SRAM |
| sram_dq_oe | output | 1 | Enables sram_dq_o onto the bus |
| sram_dq_i | input | 16 | Data returned by the SRAM |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| vid_de | output | 1 | Visible pixel on vid_rgb |
| vid_rgb | output | 12 | Pixel colour, red in the top nibble |

## Verification
A scan counter that slips shows at once as the wrong word on `vid_rgb`. It also shows as `vid_de` going high in a slot that should be black, or as an SRAM strobe during blanking. Each of these is caught within one slot by comparing every pixel against the bench's own copy of the memory. A fault in the processor window decode shows on the next clock as a missing or extra `cpu_ack`, or later as a changed pixel. A collision slot that stalls the scan instead of passing bus data shifts every later pixel of that line by one. So a fault in the priority rule is exposed within the same line.

// File: rtl/fb_arbiter.sv
module fb_arbiter #(
  parameter int H_ACT  = 800,
  parameter int V_ACT  = 480,
  parameter int H_TOT  = 1056,
  parameter int V_TOT  = 525,
  parameter int CPU_AW = 24,
  parameter int unsigned BASE = 'h41_0000,
  localparam int FB_WORDS = H_ACT * V_ACT,
  localparam int AW = $clog2(FB_WORDS),
  localparam int HW = $clog2(H_TOT),
  localparam int VW = $clog2(V_TOT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [15:0]       cpu_wdata,
  output logic              cpu_ack,
  output logic [15:0]       cpu_rdata,
  output logic [AW-1:0]     sram_addr,
  output logic [15:0]       sram_dq_o,
  output logic              sram_dq_oe,
  input  logic [15:0]       sram_dq_i,
  output logic              sram_ce_n,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic              vid_de,
  output logic [11:0]       vid_rgb
);

  localparam logic [CPU_AW-1:0] WIN_LO = CPU_AW'(BASE);
  localparam logic [CPU_AW-1:0] WIN_HI = CPU_AW'(BASE + FB_WORDS);

  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  logic [AW-1:0] scan_addr;
  logic [CPU_AW-1:0] cpu_off;
  logic [15:0] bus;
  logic in_area, cpu_hit, vid_rd, line_end, frame_end;

  assign in_area   = (hcnt < HW'(H_ACT)) && (vcnt < VW'(V_ACT));
  assign cpu_hit   = rst_n && cpu_req && (cpu_addr >= WIN_LO) && (cpu_addr < WIN_HI);
  assign vid_rd    = rst_n && in_area && !cpu_hit;
  assign line_end  = hcnt == HW'(H_TOT - 1);
  assign frame_end = line_end && (vcnt == VW'(V_TOT - 1));
  assign cpu_off   = cpu_addr - WIN_LO;

  assign sram_addr  = cpu_hit ? cpu_off[AW-1:0] : scan_addr;
  assign sram_dq_o  = cpu_wdata;
  assign sram_dq_oe = cpu_hit && cpu_we;
  assign sram_we_n  = !(cpu_hit && cpu_we);
  assign sram_oe_n  = !(vid_rd || (cpu_hit && !cpu_we));
  assign sram_ce_n  = !(vid_rd || cpu_hit);
  assign bus        = sram_dq_oe ? sram_dq_o : sram_dq_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcnt      <= '0;
      vcnt      <= '0;
      scan_addr <= '0;
    end else begin
      hcnt <= line_end ? '0 : hcnt + HW'(1);
      if (frame_end)
        vcnt <= '0;
      else if (line_end)
        vcnt <= vcnt + VW'(1);
      if (frame_end)
        scan_addr <= '0;
      else if (in_area)
        scan_addr <= scan_addr + AW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vid_de    <= 1'b0;
      vid_rgb   <= '0;
      cpu_ack   <= 1'b0;
      cpu_rdata <= '0;
    end else begin
      vid_de  <= in_area;
      vid_rgb <= in_area ? bus[11:0] : 12'h000;
      cpu_ack <= cpu_hit;
      if (cpu_hit && !cpu_we)
        cpu_rdata <= bus;
    end
  end

  // R5 R6
  ack_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_hit |=> cpu_ack);

  // R7
  ack_only_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack |-> $past(cpu_hit));

  // R5
  we_from_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> (cpu_req && cpu_we));

  // R5
  bus_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!sram_we_n && !sram_oe_n));

  // R4
  blank_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vid_de |-> (vid_rgb == 12'h000));

  // R4
  blank_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_ce_n && !cpu_hit) |-> in_area);

  // R10
  frame_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hcnt == '0 && vcnt == '0) |-> (scan_addr == '0));

endmodule

// File: tb/tb_fb_arbiter.sv
module tb_fb_arbiter;
  localparam int H = 8, V = 4, HT = 12, VT = 6, CAW = 16;
  localparam int unsigned BASE = 'h100;
  localparam int AW = $clog2(H * V);

  logic clk = 0, rst_n = 0;
  logic cpu_req = 0, cpu_we = 0;
  logic [CAW-1:0] cpu_addr = '0;
  logic [15:0] cpu_wdata = '0;
  logic cpu_ack; logic [15:0] cpu_rdata;
  logic [AW-1:0] sram_addr; logic [15:0] sram_dq_o, sram_dq_i;
  logic sram_dq_oe, sram_ce_n, sram_oe_n, sram_we_n, vid_de;
  logic [11:0] vid_rgb;

  logic [15:0] mem [0:H*V-1];
  int checks = 0, fails = 0;
  int ph = 0, pv = 0, frames = 0;
  logic mon_on = 0, cpu_was = 0;
  logic s_ack, s_de; logic [15:0] s_rdata; logic [11:0] s_rgb;

  fb_arbiter #(.H_ACT(H), .V_ACT(V), .H_TOT(HT), .V_TOT(VT), .CPU_AW(CAW), .BASE(BASE)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata), .sram_addr(sram_addr),
    .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe), .sram_dq_i(sram_dq_i),
    .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
    .vid_de(vid_de), .vid_rgb(vid_rgb));

  always #10 clk = ~clk;

  assign sram_dq_i = (!sram_ce_n && !sram_oe_n) ? mem[sram_addr] : 16'h0BAD;
  always @(posedge clk) if (!sram_ce_n && !sram_we_n) mem[sram_addr] <= sram_dq_o;
  always @(posedge clk) cpu_was <= cpu_req;

  task automatic check(input string req, input logic ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (mon_on) begin
    if (!cpu_was) begin
      if (ph < H && pv < V)
        check((frames > 0 && ph == 0 && pv == 0) ? "R10" : "R2 R3",
              vid_de && vid_rgb == mem[pv*H+ph][11:0],
              {vid_de, vid_rgb}, {1'b1, mem[pv*H+ph][11:0]});
      else
        check("R4", !vid_de && vid_rgb == 0, {vid_de, vid_rgb}, 0);
    end
    if (ph == HT - 1) begin
      ph = 0;
      if (pv == VT - 1) begin pv = 0; frames++; end else pv++;
    end else ph++;
  end

  always @(negedge clk) if (mon_on) begin
    #3;
    if (!(ph < H && pv < V) && !cpu_req)
      check("R4", sram_ce_n == 1'b1, sram_ce_n, 1);
  end

  task automatic cpu_go(input logic we, input logic [CAW-1:0] a, input logic [15:0] d);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    s_ack = cpu_ack; s_rdata = cpu_rdata; s_rgb = vid_rgb; s_de = vid_de;
    #1 cpu_req = 0; cpu_we = 0;
  endtask

  task automatic wait_pos(input int x, input int y);
    do begin @(negedge clk); #1; end while (!(ph == x && pv == y));
  endtask

  localparam logic [23:0] VEC [8] = '{
    {8'd0, 16'hFABC}, {8'd31, 16'h0123}, {8'd5, 16'h1F00}, {8'd6, 16'h20F0},
    {8'd12, 16'h000F}, {8'd19, 16'hE777}, {8'd24, 16'h0555}, {8'd9, 16'h9C3A}};

  initial begin
    logic [15:0] keep4, keep7;
    for (int i = 0; i < H*V; i++) mem[i] = {4'hF, 12'(i * 273 ^ 165)};
    keep4 = mem[4]; keep7 = mem[7];
    repeat (3) @(negedge clk);
    check("R1", !vid_de && vid_rgb == 0 && !cpu_ack, {vid_de, vid_rgb, cpu_ack}, 0);
    check("R1", sram_ce_n && sram_oe_n && sram_we_n, {sram_ce_n, sram_oe_n, sram_we_n}, 7);
    #1 rst_n = 1; mon_on = 1;
    repeat (2 * HT * VT) @(negedge clk);

    foreach (VEC[k]) begin
      @(negedge clk); #1;
      cpu_go(1, CAW'(BASE) + CAW'(VEC[k][23:16]), VEC[k][15:0]);
      check("R5", s_ack, s_ack, 1);
      @(negedge clk); #1;
      cpu_go(0, CAW'(BASE) + CAW'(VEC[k][23:16]), 16'h0);
      check("R6", s_ack && s_rdata == VEC[k][15:0], s_rdata, VEC[k][15:0]);
    end

    // R9: neighbours of the 5/6 pair keep their words
    @(negedge clk); #1; cpu_go(0, CAW'(BASE + 4), 0);
    check("R9", s_rdata == keep4, s_rdata, keep4);
    @(negedge clk); #1; cpu_go(0, CAW'(BASE + 7), 0);
    check("R9", s_rdata == keep7, s_rdata, keep7);

    // R7: out-of-window requests
    @(negedge clk); #1;
    cpu_req = 1; cpu_we = 1; cpu_addr = CAW'(BASE - 1); cpu_wdata = 16'h7777;
    #1 check("R7", sram_we_n == 1'b1, sram_we_n, 1);
    @(negedge clk); check("R7", cpu_ack == 1'b0, cpu_ack, 0);
    #1 cpu_addr = CAW'(BASE + H*V);
    #1 check("R7", sram_we_n == 1'b1, sram_we_n, 1);
    @(negedge clk); check("R7", cpu_ack == 1'b0, cpu_ack, 0);
    #1 cpu_req = 0; cpu_we = 0;
    @(negedge clk); #1; cpu_go(0, CAW'(BASE + 31), 0);
    check("R7", s_rdata == 16'h0123, s_rdata, 16'h0123);

    // R8: collisions in visible slots
    wait_pos(2, 1);
    cpu_go(1, CAW'(BASE + 20), 16'hA5C3);
    check("R8", s_de && s_rgb == 12'h5C3, s_rgb, 12'h5C3);
    wait_pos(4, 2);
    cpu_go(0, CAW'(BASE + 0), 0);
    check("R8", s_de && s_rgb == 12'hABC, s_rgb, 12'hABC);
    check("R8", s_rdata == 16'hFABC, s_rdata, 16'hFABC);

    repeat (3 * HT * VT) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #4_000_000;
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule